// File: doc/BRIEF.md
# Pipelined CORDIC Mixer with Numerically Controlled Oscillator

This block shifts a stream of real samples down to baseband for AM demodulation. A 32-bit binary-angle phase accumulator advances by a programmable tuning word on every clock. A fully unrolled, rotation-mode CORDIC pipeline then turns each incoming sample, taken as the vector (sample, 0), through the current phase. The two results are the in-phase product sample·cos(phase) and the quadrature product sample·sin(phase), both scaled by the uncompensated CORDIC gain K ≈ 1.6468.

A new sample can enter on every clock. A valid flag travels with the data, so gaps in the input stream come out as gaps in the output stream. The tuning word is computed elsewhere as round(2^32 · f/fs). Gain correction, filtering and decimation belong to later blocks.

Before the iterations, a quadrant pre-fold moves the angle into ±90° (the quadrants are named QUAD_I to QUAD_IV by the top two phase bits). Each of the 16 stages then applies one shift-and-add micro-rotation. The direction of each micro-rotation is chosen from the sign of the residual angle.

Top module: `cordic_mixer`

## Requirements
- R1: An active-low reset is asynchronous. It clears the phase accumulator to zero and takes out_valid low at once. While reset is held, out_i and out_q read zero.
- R2: The phase advances by tune_word on every clock edge, whether or not a sample is valid, and wraps modulo 2^32 (one turn = 2^32 units). A sample accepted at an edge is rotated by the phase held just before that edge. The first sample accepted after reset uses phase 0.
- R3: For an accepted sample s at phase p, out_i ≈ K·s·cos(2π·p/2^32) and out_q ≈ K·s·sin(2π·p/2^32), with K ≈ 1.64676. Each output is within 32 LSB of these values.
- R4: R3 holds in all four quadrants of the phase (top two phase bits 00, 01, 10, 11). It also holds for full-scale samples including −32768. The 18-bit signed outputs never exceed ±(K·32768 + 64).
- R5: The result of a sample appears exactly 16 clocks after the edge that accepts it. One sample is accepted per clock. out_valid stays low for the first 16 clocks after reset.
- R6: out_valid is the in_valid of 16 edges earlier. A clock with in_valid low produces no valid output, and every valid input produces exactly one valid output, in order.
- R7: A valid zero sample produces out_i = 0 and out_q = 0 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | 32 | Phase increment per clock (2^32 units per turn) |
| in_valid | input | 1 | in_sample carries a sample this clock |
| in_sample | input | 16 | Signed two's-complement input sample |
| out_valid | output | 1 | out_i/out_q carry a result |
| out_i | output | 18 | Signed in-phase product, gain K |
| out_q | output | 18 | Signed quadrature product, gain K |

## Verification
The bench keeps its own phase model and sweeps tuning words chosen so that the phase lands in every quadrant. It includes the exact half-turn and quarter-turn points. A wrong quadrant fold shows up there as outputs with the wrong sign or as collapsed outputs. Full-scale negative samples at second- and third-quadrant phases target negation overflow and missing guard bits, which would make the result wrap to the opposite sign. A 1/80-turn tuning word runs through many wraps, and a reset in mid-stream checks that the phase restarts at zero rather than carrying over. Input bubbles and a 16-clock latency stamp on every item catch a valid flag that is misaligned with the data or a pipeline that is one stage too short or too long.

// File: rtl/mixer_pkg.sv
package mixer_pkg;

    // Quadrant of a binary angle, taken from its two top bits
    typedef enum logic [1:0] {
        QUAD_I   = 2'b00,
        QUAD_II  = 2'b01,
        QUAD_III = 2'b10,
        QUAD_IV  = 2'b11
    } quad_e;

    // atan(2^-idx) expressed with 2^32 units per full turn
    function automatic logic [31:0] atan_turn32(input int idx);
        logic [31:0] a;
        case (idx)
            0:  a = 32'h2000_0000;
            1:  a = 32'h12E4_051E;
            2:  a = 32'h09FB_385B;
            3:  a = 32'h0511_11D4;
            4:  a = 32'h028B_0D43;
            5:  a = 32'h0145_D7E1;
            6:  a = 32'h00A2_F61E;
            7:  a = 32'h0051_7C55;
            8:  a = 32'h0028_BE53;
            9:  a = 32'h0014_5F2F;
            10: a = 32'h000A_2F98;
            11: a = 32'h0005_17CC;
            12: a = 32'h0002_8BE6;
            13: a = 32'h0001_45F3;
            14: a = 32'h0000_A2FA;
            15: a = 32'h0000_517D;
            default: a = 32'h0000_0000;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] step,
    output logic [PH_W-1:0] phase
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else begin
            phase <= phase + step;
        end
    end

endmodule

// File: rtl/quad_fold.sv
module quad_fold
    import mixer_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DW       = 18,
    parameter int PH_W     = 32
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic        [PH_W-1:0]     phase,
    output logic signed [DW-1:0]       x0,
    output logic signed [PH_W-1:0]     z0
);

    localparam int GUARD = DW - SAMPLE_W;

    logic signed [DW-1:0] ext;
    quad_e                quad;

    assign ext  = {{GUARD{sample[SAMPLE_W-1]}}, sample};
    assign quad = quad_e'(phase[PH_W-1 -: 2]);

    // Angles beyond +-90 deg: negate the vector and take half a turn off
    always_comb begin
        unique case (quad)
            QUAD_I, QUAD_IV: begin
                x0 = ext;
                z0 = phase;
            end
            QUAD_II, QUAD_III: begin
                x0 = -ext;
                z0 = {~phase[PH_W-1], phase[PH_W-2:0]};
            end
            default: begin
                x0 = ext;
                z0 = phase;
            end
        endcase
    end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
    import mixer_pkg::*;
#(
    parameter int DW   = 18,
    parameter int PH_W = 32,
    parameter int IDX  = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   v_i,
    input  logic signed [DW-1:0]   x_i,
    input  logic signed [DW-1:0]   y_i,
    input  logic signed [PH_W-1:0] z_i,
    output logic                   v_o,
    output logic signed [DW-1:0]   x_o,
    output logic signed [DW-1:0]   y_o,
    output logic signed [PH_W-1:0] z_o
);

    localparam logic [31:0]     ANG32 = atan_turn32(IDX);
    localparam logic [PH_W-1:0] ANG   = ANG32[31 -: PH_W];

    logic signed [DW-1:0] x_sh;
    logic signed [DW-1:0] y_sh;
    logic                 ccw;

    assign x_sh = x_i >>> IDX;
    assign y_sh = y_i >>> IDX;
    assign ccw  = ~z_i[PH_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            v_o <= v_i;
            if (ccw) begin
                x_o <= x_i - y_sh;
                y_o <= y_i + x_sh;
                z_o <= z_i - ANG;
            end else begin
                x_o <= x_i + y_sh;
                y_o <= y_i - x_sh;
                z_o <= z_i + ANG;
            end
        end
    end

endmodule

// File: rtl/cordic_mixer.sv
module cordic_mixer
    import mixer_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int GUARD    = 2,
    parameter int PH_W     = 32,
    parameter int STAGES   = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [PH_W-1:0]                    tune_word,
    input  logic                               in_valid,
    input  logic signed [SAMPLE_W-1:0]         in_sample,
    output logic                               out_valid,
    output logic signed [SAMPLE_W+GUARD-1:0]   out_i,
    output logic signed [SAMPLE_W+GUARD-1:0]   out_q
);

    localparam int DW = SAMPLE_W + GUARD;

    logic [PH_W-1:0]        phase_q;
    logic                   vp [0:STAGES];
    logic signed [DW-1:0]   xp [0:STAGES];
    logic signed [DW-1:0]   yp [0:STAGES];
    logic signed [PH_W-1:0] zp [0:STAGES];
    logic                   unused_resid;

    nco_accum #(.PH_W(PH_W)) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (tune_word),
        .phase (phase_q)
    );

    quad_fold #(.SAMPLE_W(SAMPLE_W), .DW(DW), .PH_W(PH_W)) u_fold (
        .sample (in_sample),
        .phase  (phase_q),
        .x0     (xp[0]),
        .z0     (zp[0])
    );

    assign vp[0] = in_valid;
    assign yp[0] = '0;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        cordic_stage #(.DW(DW), .PH_W(PH_W), .IDX(g)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (vp[g]),
            .x_i   (xp[g]),
            .y_i   (yp[g]),
            .z_i   (zp[g]),
            .v_o   (vp[g+1]),
            .x_o   (xp[g+1]),
            .y_o   (yp[g+1]),
            .z_o   (zp[g+1])
        );
    end

    assign out_valid    = vp[STAGES];
    assign out_i        = xp[STAGES];
    assign out_q        = yp[STAGES];
    assign unused_resid = ^zp[STAGES];

endmodule

// File: rtl/mixer_chk.sv
module mixer_chk #(
    parameter int SAMPLE_W = 16,
    parameter int DW       = 18,
    parameter int PH_W     = 32,
    parameter int STAGES   = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [PH_W-1:0]            tune_word,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] in_sample,
    input logic                       out_valid,
    input logic signed [DW-1:0]       out_i,
    input logic signed [DW-1:0]       out_q,
    input logic [PH_W-1:0]            phase
);

    localparam int LIM = ((2 ** (SAMPLE_W - 1)) * 1647) / 1000 + 64;

    int                unsigned edges;
    logic [STAGES-1:0] vsh;
    logic [STAGES-1:0] zsh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges <= 0;
            vsh   <= '0;
            zsh   <= '0;
        end else begin
            if (edges < STAGES) edges <= edges + 1;
            vsh <= {vsh[STAGES-2:0], in_valid};
            zsh <= {zsh[STAGES-2:0], in_valid && (in_sample == '0)};
        end
    end

    // R2
    nco_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase == $past(phase) + $past(tune_word));

    // R5
    startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edges < STAGES) |-> !out_valid);

    // R6
    valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vsh[STAGES-1]);

    // R7
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zsh[STAGES-1]) |-> (out_i == 0 && out_q == 0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_i <= LIM && out_i >= -LIM && out_q <= LIM && out_q >= -LIM));

endmodule

bind cordic_mixer mixer_chk #(
    .SAMPLE_W (SAMPLE_W),
    .DW       (SAMPLE_W + GUARD),
    .PH_W     (PH_W),
    .STAGES   (STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tune_word (tune_word),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .phase     (phase_q)
);

// File: tb/tb_cordic_mixer.sv
`timescale 1ns/1ps
module tb_cordic_mixer;

    localparam real KG   = 1.6467602581;
    localparam real PI   = 3.14159265358979;
    localparam real TOL  = 32.0;
    localparam int  LAT  = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [31:0]        tune_word = '0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic signed [17:0] out_i;
    logic signed [17:0] out_q;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [31:0] ph_m;

    real qe_i[$];
    real qe_q[$];
    int  qc[$];
    int  qs[$];

    always #2.5 clk = ~clk;

    cordic_mixer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    // independent phase model (R2)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_m <= '0;
        else        ph_m <= ph_m + tune_word;
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic drive(input logic signed [15:0] s, input bit v);
        real th;
        @(negedge clk);
        in_sample = s;
        in_valid  = v;
        if (v) begin
            th = 2.0 * PI * real'(ph_m) / 4294967296.0;
            qe_i.push_back(KG * real'(s) * $cos(th));
            qe_q.push_back(KG * real'(s) * $sin(th));
            qc.push_back(cyc);
            qs.push_back(int'(s));
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (qc.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected out_valid: got 1 exp 0");
            end else begin
                real ei, eq, di, dq;
                int  c0, s0;
                ei = qe_i.pop_front();
                eq = qe_q.pop_front();
                c0 = qc.pop_front();
                s0 = qs.pop_front();
                if (cyc - c0 != LAT) begin
                    errors++;
                    $display("FAIL R5 latency: got %0d exp %0d", cyc - c0, LAT);
                end
                checks++;
                if (s0 == 0) begin
                    if (out_i != 0 || out_q != 0) begin
                        errors++;
                        $display("FAIL R7 zero sample: got %0d,%0d exp 0,0", out_i, out_q);
                    end
                end else begin
                    di = real'(out_i) - ei;
                    dq = real'(out_q) - eq;
                    if (di > TOL || di < -TOL || dq > TOL || dq < -TOL) begin
                        errors++;
                        $display("FAIL R3/R4 sample %0d: got %0d,%0d exp %0.1f,%0.1f",
                                 s0, out_i, out_q, ei, eq);
                    end
                end
            end
        end
    end

    task automatic flush_model();
        qe_i.delete(); qe_q.delete(); qc.delete(); qs.delete();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_i !== 18'sd0 || out_q !== 18'sd0) begin
            errors++;
            $display("FAIL R1 reset state: got %b/%0d/%0d exp 0/0/0", out_valid, out_i, out_q);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3: 1/80 turn, many wraps, constant sample
        tune_word = 32'h0333_3333;
        for (int n = 0; n < 200; n++) drive(16'sd20000, 1'b1);

        // R4: every quadrant, full scale, including exact quarter/half turns
        tune_word = 32'h4000_0000;
        for (int n = 0; n < 8; n++) drive(16'sh8000, 1'b1);
        for (int n = 0; n < 8; n++) drive(16'sd32767, 1'b1);
        tune_word = 32'h1234_5679;
        for (int n = 0; n < 64; n++) drive(((n % 3) == 0) ? 16'sh8000 : 16'sd32767 - 16'(n), 1'b1);

        // R7: zero samples among others
        tune_word = 32'h2710_0000;
        for (int n = 0; n < 20; n++) drive((n % 2 == 0) ? 16'sd0 : -16'sd12345, 1'b1);

        // R6: bubbles with random samples and tuning words
        for (int n = 0; n < 300; n++) begin
            if (n % 25 == 0) tune_word = $urandom;
            drive(16'($urandom), ($urandom % 3) != 0);
        end
        drive(16'sd0, 1'b0);

        // R1/R2: asynchronous reset in mid-stream, phase restarts at zero
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 async clear: got %b exp 0", out_valid);
        end
        flush_model();
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tune_word = 32'h4000_0000;
        for (int n = 0; n < 6; n++) drive(16'sd10000, 1'b1);
        tune_word = 32'h0;
        for (int n = 0; n < 6; n++) drive(-16'sd10000, 1'b1);
        drive(16'sd0, 1'b0);

        repeat (LAT + 8) @(negedge clk);
        // R6: every valid input produced exactly one output
        checks++;
        if (qc.size() != 0) begin
            errors++;
            $display("FAIL R6 missing outputs: got %0d pending exp 0", qc.size());
        end
        finish_run();
    end

endmodule